// File: doc/BRIEF.md
# Circular Audio Sample Fetch Channel

This block is a single playback channel that reads audio sample data from memory in fixed 32-byte blocks and passes each block, unchanged, to a downstream audio encoder. Software sets it up through a small set of 16-bit registers. The start byte address is split across three registers: an upper halfword, a lower halfword, and a narrow register for the topmost address bits. A fourth register holds an enable bit and a buffer length counted in blocks.

When software sets the enable bit, the channel takes a snapshot of the start address and length. It then fetches consecutive blocks over a request/acknowledge read port and offers each one on a valid/ready stream. It counts the blocks still to be delivered in the current pass. When the last block of a pass is accepted, it raises a one-cycle pass-complete pulse, returns to the snapshot start address and keeps going while the enable bit is still set. For one-shot playback, software clears the enable bit before the final block is accepted. A parameter decides whether the top-address-bits register can be rewritten freely or keeps its first written value until reset.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset, every register reads zero, `mem_req`, `blk_valid` and `pass_done` are low, and no fetch starts.
- R2: Register map (`reg_addr` is a byte offset, read data is combinational). 0x30 holds address bits [31:16]. 0x32 holds address bits [15:0], and its bits [4:0] read zero and ignore writes. 0x34 holds address bits [34:32] in bits [2:0], and its upper bits read zero. 0x36 holds enable in bit 15 and the length in blocks in bits [14:0]. 0x3A holds the remaining-block count in bits [14:0] and ignores writes. Any other offset reads zero.
- R3: A write that takes the enable bit from 0 to 1 snapshots the start address and length and loads the remaining count with that length. The first fetch goes to the snapshot address. Address register writes made later have no effect until the next 0-to-1 enable transition.
- R4: Successive fetches go to addresses 32 bytes apart, with carries into the upper address bits. `mem_req` and `mem_addr` hold steady until `mem_ack`. Each fetched block is offered on `blk_data` and held steady until `blk_ready`.
- R5: The remaining count drops by exactly one each time a block is accepted on the stream.
- R6: When the last block of a pass is accepted, `pass_done` is high for exactly one cycle, the remaining count reloads to the snapshot length, and, if the channel is still enabled, the next fetch goes to the snapshot start address.
- R7: After enable is cleared, the block already in flight is still delivered and counted. No further fetch is issued after that.
- R8: A snapshot length of zero issues no fetch while enabled, and the remaining count reads zero.
- R9: With `LOCK_TOP`=1, the top-address register keeps its first written value and ignores later writes until reset. With `LOCK_TOP`=0, it can be rewritten at any time.
- R10: Writing the control register with the enable bit set while the channel is already enabled does not restart the pass. Only the read-back length field changes, and the remaining count and the snapshot length are left as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| mem_req | output | 1 | Block read request |
| mem_addr | output | ADDR_W (35) | Byte address of the requested block, 32-byte aligned |
| mem_ack | input | 1 | Memory returns `mem_data` for the pending request |
| mem_data | input | DATA_W (256) | Block data from memory |
| blk_valid | output | 1 | A block is offered to the encoder |
| blk_data | output | DATA_W (256) | Block offered to the encoder |
| blk_ready | input | 1 | Encoder accepts the offered block |
| pass_done | output | 1 | One-cycle pulse when a buffer pass completes |

## Verification
The bench identifies each delivered block by tagging the memory data with its own fetch address. A corrupted cursor therefore shows up in the very next block accepted on the stream, and a wrong wrap point shows up as a missing or misplaced jump back to the start address. Because the bench stalls the stream, it can step one block at a time. A remaining count that decrements wrongly or misses its reload appears in the read-back register right after the acceptance that caused it. A channel that fails to stop or idle is caught by watching `mem_req` over a window of quiet cycles.

// File: rtl/ardma_pkg.sv
`timescale 1ns/1ps
package ardma_pkg;
   localparam logic [7:0] OFF_ADDR_HI  = 8'h30;
   localparam logic [7:0] OFF_ADDR_LO  = 8'h32;
   localparam logic [7:0] OFF_ADDR_TOP = 8'h34;
   localparam logic [7:0] OFF_CTRL     = 8'h36;
   localparam logic [7:0] OFF_REMAIN   = 8'h3A;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_FETCH = 2'd1,
      ENG_SEND  = 2'd2
   } eng_state_t;
endpackage

// File: rtl/ardma_regs.sv
`timescale 1ns/1ps
module ardma_regs #(
   parameter int TOP_W    = 3,
   parameter int LEN_W    = 15,
   parameter int OFS_W    = 5,
   parameter bit LOCK_TOP = 1'b1,
   localparam int BLK_AW  = TOP_W + 32 - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen_i,
   input  logic [7:0]        addr_i,
   input  logic [15:0]       wdata_i,
   output logic [15:0]       rdata_o,
   input  logic [LEN_W-1:0]  remain_i,
   output logic              en_o,
   output logic              start_o,
   output logic [BLK_AW-1:0] start_blk_o,
   output logic [LEN_W-1:0]  start_len_o
);
   import ardma_pkg::*;

   logic [15:0]       hi_q;
   logic [15-OFS_W:0] lo_q;
   logic [TOP_W-1:0]  top_q;
   logic              en_q;
   logic [LEN_W-1:0]  len_q;
   logic              top_wen;
   logic              ctrl_wen;

   assign top_wen  = wen_i && (addr_i == OFF_ADDR_TOP);
   assign ctrl_wen = wen_i && (addr_i == OFF_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         en_q  <= 1'b0;
         len_q <= '0;
      end else begin
         if (wen_i && addr_i == OFF_ADDR_HI) hi_q <= wdata_i;
         if (wen_i && addr_i == OFF_ADDR_LO) lo_q <= wdata_i[15:OFS_W];
         if (ctrl_wen) begin
            en_q  <= wdata_i[15];
            len_q <= wdata_i[LEN_W-1:0];
         end
      end
   end

   generate
      if (LOCK_TOP) begin : g_top_locked
         logic locked_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               top_q    <= '0;
               locked_q <= 1'b0;
            end else if (top_wen && !locked_q) begin
               top_q    <= wdata_i[TOP_W-1:0];
               locked_q <= 1'b1;
            end
         end
         // R9: once the first write has landed the field never moves
         assert_top_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
            locked_q |=> $stable(top_q));
      end else begin : g_top_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       top_q <= '0;
            else if (top_wen) top_q <= wdata_i[TOP_W-1:0];
         end
      end
   endgenerate

   assign en_o        = en_q;
   assign start_o     = ctrl_wen && wdata_i[15] && !en_q;
   assign start_blk_o = {top_q, hi_q, lo_q};
   assign start_len_o = wdata_i[LEN_W-1:0];

   always_comb begin
      case (addr_i)
         OFF_ADDR_HI:  rdata_o = hi_q;
         OFF_ADDR_LO:  rdata_o = {lo_q, {OFS_W{1'b0}}};
         OFF_ADDR_TOP: rdata_o = 16'(top_q);
         OFF_CTRL:     rdata_o = {en_q, 15'(len_q)};
         OFF_REMAIN:   rdata_o = 16'(remain_i);
         default:      rdata_o = '0;
      endcase
   end

   // R3: a start strobe is only ever seen on a disabled channel
   assert_start_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> en_q);
endmodule

// File: rtl/ardma_engine.sv
`timescale 1ns/1ps
module ardma_engine #(
   parameter int LEN_W  = 15,
   parameter int OFS_W  = 5,
   parameter int BLK_AW = 30,
   parameter int DATA_W = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              start_i,
   input  logic [BLK_AW-1:0] start_blk_i,
   input  logic [LEN_W-1:0]  start_len_i,
   output logic [LEN_W-1:0]  remain_o,
   output logic              mem_req,
   output logic [BLK_AW+OFS_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_data,
   output logic              blk_valid,
   output logic [DATA_W-1:0] blk_data,
   input  logic              blk_ready,
   output logic              pass_done
);
   import ardma_pkg::*;

   eng_state_t        st_q, st_d;
   logic [BLK_AW-1:0] base_q, base_d, cur_q, cur_d, req_q;
   logic [LEN_W-1:0]  len_q, len_d, rem_q, rem_d;
   logic              stale_q, stale_d;
   logic              wrap;
   logic              done_blk;
   logic              fetched;
   logic [DATA_W-1:0] buf_q;
   logic              pulse_q;

   assign done_blk = (st_q == ENG_SEND) && blk_ready;
   assign fetched  = (st_q == ENG_FETCH) && mem_ack;

   always_comb begin
      base_d  = base_q;
      len_d   = len_q;
      rem_d   = rem_q;
      cur_d   = cur_q;
      stale_d = stale_q;
      wrap    = 1'b0;
      if (start_i) begin
         base_d  = start_blk_i;
         len_d   = start_len_i;
         rem_d   = start_len_i;
         cur_d   = start_blk_i;
         stale_d = (st_q != ENG_IDLE) && !done_blk;
      end else if (done_blk) begin
         stale_d = 1'b0;
         if (!stale_q) begin
            if (rem_q == LEN_W'(1)) begin
               rem_d = len_q;
               cur_d = base_q;
               wrap  = 1'b1;
            end else begin
               rem_d = rem_q - LEN_W'(1);
               cur_d = cur_q + BLK_AW'(1);
            end
         end
      end
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         ENG_IDLE:  if (en_i && rem_q != '0) st_d = ENG_FETCH;
         ENG_FETCH: if (mem_ack) st_d = ENG_SEND;
         ENG_SEND:  if (blk_ready) st_d = (en_i && rem_d != '0) ? ENG_FETCH : ENG_IDLE;
         default:   st_d = ENG_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ENG_IDLE;
         base_q  <= '0;
         len_q   <= '0;
         rem_q   <= '0;
         cur_q   <= '0;
         req_q   <= '0;
         stale_q <= 1'b0;
         buf_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         base_q  <= base_d;
         len_q   <= len_d;
         rem_q   <= rem_d;
         cur_q   <= cur_d;
         stale_q <= stale_d;
         pulse_q <= wrap;
         if (st_d == ENG_FETCH && st_q != ENG_FETCH) req_q <= cur_d;
         if (fetched) buf_q <= mem_data;
      end
   end

   assign mem_req   = (st_q == ENG_FETCH);
   assign mem_addr  = {req_q, {OFS_W{1'b0}}};
   assign blk_valid = (st_q == ENG_SEND);
   assign blk_data  = buf_q;
   assign remain_o  = rem_q;
   assign pass_done = pulse_q;

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   assert_blk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_data)));
   assert_pass_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done);
   assert_remain_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q <= len_q);
   assert_live_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ENG_SEND && !stale_q) |-> (rem_q != '0));
   assert_zero_len_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ENG_IDLE && rem_q == '0 && !start_i) |=> !mem_req);
   assert_stopped_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ENG_IDLE && !en_i) |=> !mem_req);
endmodule

// File: rtl/audio_ring_dma.sv
`timescale 1ns/1ps
module audio_ring_dma #(
   parameter int TOP_W     = 3,
   parameter int LEN_W     = 15,
   parameter int BLK_BYTES = 32,
   parameter bit LOCK_TOP  = 1'b1,
   localparam int OFS_W    = $clog2(BLK_BYTES),
   localparam int ADDR_W   = TOP_W + 32,
   localparam int BLK_AW   = ADDR_W - OFS_W,
   localparam int DATA_W   = BLK_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [7:0]        reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_data,
   output logic              blk_valid,
   output logic [DATA_W-1:0] blk_data,
   input  logic              blk_ready,
   output logic              pass_done
);
   generate
      if (LEN_W < 1 || LEN_W > 15) begin : g_bad_len
         $error("LEN_W must be within 1..15");
      end
      if (TOP_W < 1 || TOP_W > 16) begin : g_bad_top
         $error("TOP_W must be within 1..16");
      end
      if (BLK_BYTES < 2 || BLK_BYTES > 256 || (1 << OFS_W) != BLK_BYTES) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two within 2..256");
      end
   endgenerate

   logic              en;
   logic              start;
   logic [BLK_AW-1:0] start_blk;
   logic [LEN_W-1:0]  start_len;
   logic [LEN_W-1:0]  remain;

   ardma_regs #(
      .TOP_W(TOP_W), .LEN_W(LEN_W), .OFS_W(OFS_W), .LOCK_TOP(LOCK_TOP)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wen_i(reg_wen), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
      .remain_i(remain), .en_o(en), .start_o(start),
      .start_blk_o(start_blk), .start_len_o(start_len)
   );

   ardma_engine #(
      .LEN_W(LEN_W), .OFS_W(OFS_W), .BLK_AW(BLK_AW), .DATA_W(DATA_W)
   ) eng_i (
      .clk(clk), .rst_n(rst_n),
      .en_i(en), .start_i(start), .start_blk_i(start_blk), .start_len_i(start_len),
      .remain_o(remain),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
      .blk_valid(blk_valid), .blk_data(blk_data), .blk_ready(blk_ready),
      .pass_done(pass_done)
   );
endmodule

// File: tb/audio_ring_dma_tb_top.sv
`timescale 1ns/1ps
module audio_ring_dma_tb_top;
   localparam int ADDR_W = 35;
   localparam int DATA_W = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wen = 1'b0;
   logic [7:0]        reg_addr = '0;
   logic [15:0]       reg_wdata = '0;
   logic [15:0]       reg_rdata;
   logic              mem_req;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_ack = 1'b0;
   logic [DATA_W-1:0] mem_data = '0;
   logic              blk_valid;
   logic [DATA_W-1:0] blk_data;
   logic              blk_ready = 1'b0;
   logic              pass_done;

   int n_run = 0;
   int n_fail = 0;
   int lat = 2;
   int wcnt = 0;
   int n_irq = 0;
   int n_log = 0;
   logic [ADDR_W-1:0] log_addr [0:63];

   always #2 clk = ~clk;

   audio_ring_dma dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
      .blk_valid(blk_valid), .blk_data(blk_data), .blk_ready(blk_ready),
      .pass_done(pass_done)
   );

   // memory model, stream monitor and pulse counter: sampled mid-low-phase
   initial begin
      forever begin
         @(negedge clk);
         #0.8;
         if (mem_req && !mem_ack) begin
            if (wcnt >= lat) begin
               mem_ack  = 1'b1;
               mem_data = DATA_W'(mem_addr) | (DATA_W'(16'hA5C3) << (DATA_W - 16));
               wcnt     = 0;
            end else wcnt = wcnt + 1;
         end else mem_ack = 1'b0;
         if (blk_valid && blk_ready && n_log < 64) begin
            log_addr[n_log] = blk_data[ADDR_W-1:0];
            n_log = n_log + 1;
         end
         if (pass_done) n_irq = n_irq + 1;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #0.4;
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      tick();
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wen = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input logic [15:0] exp);
      tick();
      reg_addr = a;
      #0.1;
      check(req, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic deliver_one(input string req);
      int guard = 0;
      tick();
      while (!blk_valid && guard < 1000) begin
         tick();
         guard++;
      end
      check({req, " block offered"}, 64'(blk_valid), 64'd1);
      blk_ready = 1'b1;
      tick();
      blk_ready = 1'b0;
   endtask

   task automatic quiet(input string req, input int n);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         tick();
         if (mem_req || blk_valid) bad++;
      end
      check({req, " no fetch activity"}, 64'(bad), 64'd0);
   endtask

   logic [ADDR_W-1:0] base1 = {3'b101, 16'h1234, 16'hFFC0};
   logic [ADDR_W-1:0] base2 = {3'b101, 16'h4444, 16'hFFC0};

   task automatic t_reset();
      rd_check("R1 hi", 8'h30, 16'h0);
      rd_check("R1 lo", 8'h32, 16'h0);
      rd_check("R1 top", 8'h34, 16'h0);
      rd_check("R1 ctrl", 8'h36, 16'h0);
      rd_check("R1 remain", 8'h3A, 16'h0);
      check("R1 outputs idle", 64'({mem_req, blk_valid, pass_done}), 64'd0);
      quiet("R1", 10);
   endtask

   task automatic t_regmap();
      wr(8'h30, 16'h1234);
      rd_check("R2 hi readback", 8'h30, 16'h1234);
      wr(8'h32, 16'hFFFF);
      rd_check("R2 lo low bits zero", 8'h32, 16'hFFE0);
      wr(8'h34, 16'hFFFD);
      rd_check("R2 top masked", 8'h34, 16'h0005);
      wr(8'h34, 16'h0002);
      rd_check("R9 top locked", 8'h34, 16'h0005);
      wr(8'h3A, 16'h7777);
      rd_check("R2 remain read-only", 8'h3A, 16'h0);
      rd_check("R2 unmapped", 8'h10, 16'h0);
   endtask

   task automatic t_play();
      lat = 2;
      wr(8'h32, 16'hFFC0);
      wr(8'h36, 16'h8003);
      rd_check("R2 ctrl readback", 8'h36, 16'h8003);
      rd_check("R3 remain loaded", 8'h3A, 16'd3);
      wr(8'h30, 16'h4444);
      deliver_one("R5");
      rd_check("R5 remain after 1", 8'h3A, 16'd2);
      lat = 5;
      deliver_one("R5");
      rd_check("R5 remain after 2", 8'h3A, 16'd1);
      check("R3 first block at snapshot", 64'(log_addr[0]), 64'(base1));
      check("R4 second block +32", 64'(log_addr[1]), 64'(base1 + 35'd32));
      check("R6 no pulse mid-pass", 64'(n_irq), 64'd0);
   endtask

   task automatic t_wrap();
      lat = 0;
      deliver_one("R6");
      tick();
      check("R6 pass pulse count", 64'(n_irq), 64'd1);
      rd_check("R6 remain reload", 8'h3A, 16'd3);
      check("R4 carry into upper halfword", 64'(log_addr[2]), 64'(base1 + 35'd64));
      deliver_one("R6");
      check("R6 restart at snapshot base", 64'(log_addr[3]), 64'(base1));
      rd_check("R5 remain after wrap+1", 8'h3A, 16'd2);
   endtask

   task automatic t_rewrite();
      wr(8'h36, 16'h8005);
      rd_check("R10 ctrl shows new length", 8'h36, 16'h8005);
      rd_check("R10 remain untouched", 8'h3A, 16'd2);
      deliver_one("R10");
      rd_check("R10 count continues", 8'h3A, 16'd1);
      check("R10 no restart", 64'(log_addr[4]), 64'(base1 + 35'd32));
   endtask

   task automatic t_stop();
      int g = 0;
      while (!blk_valid && g < 1000) begin tick(); g++; end
      wr(8'h36, 16'h0000);
      deliver_one("R7");
      tick();
      check("R7 in-flight block delivered", 64'(log_addr[5]), 64'(base1 + 35'd64));
      check("R6 one-shot pulse", 64'(n_irq), 64'd2);
      rd_check("R10 reload uses snapshot length", 8'h3A, 16'd3);
      quiet("R7", 20);
   endtask

   task automatic t_reenable();
      lat = 1;
      wr(8'h36, 16'h8002);
      rd_check("R3 new snapshot length", 8'h3A, 16'd2);
      deliver_one("R3");
      check("R3 new base snapshot", 64'(log_addr[6]), 64'(base2));
      tick();
      wr(8'h36, 16'h0000);
      deliver_one("R7");
      tick();
      check("R7 second in-flight", 64'(log_addr[7]), 64'(base2 + 35'd32));
      check("R6 pulse count", 64'(n_irq), 64'd3);
      quiet("R7 after stop", 20);
      check("R7 block count", 64'(n_log), 64'd8);
   endtask

   task automatic t_zero();
      wr(8'h36, 16'h8000);
      quiet("R8", 20);
      rd_check("R8 remain zero", 8'h3A, 16'd0);
      check("R8 no pulse", 64'(n_irq), 64'd3);
      wr(8'h36, 16'h0000);
   endtask

   initial begin
      #(200000 * 4);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_play();
      t_wrap();
      t_rewrite();
      t_stop();
      t_reenable();
      t_zero();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule